// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps external events against a free-running counter that lives outside it. A trigger comes either from an external pin or from the digital result bit of an analog comparator. The chosen trigger is synchronized to the clock and can optionally pass through a noise filter. An edge detector then looks for the chosen polarity. On a matching edge, the current counter value is latched into a capture register, and a capture flag is raised. The flag can be turned into an interrupt request.

Software reaches the block over a narrow byte-wide bus. The capture register is twice the bus width, so a shared temporary byte keeps multi-byte accesses consistent. On a read, software fetches the low byte first, and that read snapshots the high byte into the temporary byte. On a write, software places the high byte in the temporary byte first, and the low-byte write then commits both bytes in one cycle. Writes to the capture register are honoured only while the counter's mode uses this register as its top value.

Top module: `capture_unit`

## Requirements
- R1: With `src_cmp_sel`=0 the trigger is `pin_in`; with `src_cmp_sel`=1 it is `cmp_in`. Activity on the source that is not selected causes no capture and leaves the flag and the capture register unchanged.
- R2: With `edge_rise`=1 only a 0-to-1 transition of the selected source captures. With `edge_rise`=0 only a 1-to-0 transition captures. A pulse that has both edges captures once.
- R3: With the filter off, a source change that is set up before clock edge k is captured at edge k+3. The captured value is the `count_val` seen at edge k+3.
- R4: With `filt_en`=1, the filtered level changes only after 4 consecutive equal synchronized samples. A pulse of 3 cycles or fewer is not captured. A longer change is captured 4 cycles later than in R3, at edge k+7.
- R5: `cap_flag` goes to 1 at the same clock edge that loads the capture register. The flag also reads back as bit 0 at bus address 2.
- R6: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1. It is registered and updates at the same edge as the flag.
- R7: The flag clears when `irq_ack` is high, or on a bus write to address 2 with bit 0 = 1. A write with bit 0 = 0 leaves it set. A capture in the same cycle as a clear leaves the flag set.
- R8: A read at address 0 returns the low byte of the capture register and copies its high byte into the temporary byte. A read at address 1 returns the temporary byte, even if a capture has happened since the low-byte read. `bus_rdata` is valid in the cycle after `bus_rd`.
- R9: A write at address 1 loads the temporary byte. A write at address 0 loads {temporary byte, write data} into the capture register only when `top_mode`=1. When `top_mode`=0, the capture register keeps its value.
- R10: When a low-byte write with `top_mode`=1 and a capture fall in the same cycle, the register takes the written value. The flag is still set.
- R11: Synchronous reset clears the capture register, the temporary byte, the flag, `irq` and `bus_rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | External capture pin, asynchronous |
| cmp_in | input | 1 | Analog comparator result bit, asynchronous |
| src_cmp_sel | input | 1 | 1 selects the comparator as trigger |
| filt_en | input | 1 | Enables the 4-sample noise filter |
| edge_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| irq_en | input | 1 | Capture interrupt enable |
| top_mode | input | 1 | Counter mode uses the capture register as top; permits writes |
| count_val | input | CNT_W | Free-running counter value |
| irq_ack | input | 1 | Interrupt serviced; clears the flag |
| bus_addr | input | 2 | 0 low byte, 1 high byte/temporary, 2 flag |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W/2 | Write data |
| bus_rdata | output | CNT_W/2 | Registered read data |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. The flag follows every capture. An unobstructed capture loads the counter value from the previous cycle. A bus write wins over a capture in the same cycle. A low-byte write while `top_mode` is 0 leaves the register untouched. An acknowledge with no capture clears the flag. The request never stands without the flag, and one polarity never fires on two cycles in a row.

Some behaviour only the bench scenarios can show. These are the exact latency with and without the filter, and the rejection of short pulses. The bench also covers the isolation of the unselected source and the snapshot held in the temporary byte across an intervening capture. The cases where a capture coincides with an acknowledge or with a register write need exact edge timing, so the bench sets them up.

// File: rtl/capture_pkg.sv
package capture_pkg;
  typedef enum logic [1:0] {
    ADR_CAP_LO = 2'd0,
    ADR_CAP_HI = 2'd1,
    ADR_FLAG   = 2'd2
  } bus_adr_e;
endpackage

// File: rtl/cap_sync_filter.sv
module cap_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic filt_en,
  output logic lvl
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], synced};
      if (!filt_en)
        lvl <= synced;
      else if (&hist_q)
        lvl <= 1'b1;
      else if (~|hist_q)
        lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic edge_rise,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign evt = edge_rise ? (lvl & ~prev_q) : (~lvl & prev_q);

  AST_SINGLE_EVT: assert property (@(posedge clk) disable iff (rst)
    evt |=> (!evt || (edge_rise != $past(edge_rise)))); // R2
endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import capture_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [CNT_W-1:0] count_val,
  input  logic             top_mode,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BW-1:0]    bus_wdata,
  output logic [BW-1:0]    bus_rdata,
  output logic             cap_flag,
  output logic             irq
);
  logic [CNT_W-1:0] cap_q;
  logic [BW-1:0]    temp_q;
  logic             cpu_lo_wr;
  logic             flag_clr;
  logic             flag_nxt;

  assign cpu_lo_wr = bus_wr && (bus_addr == ADR_CAP_LO) && top_mode;
  assign flag_clr  = irq_ack || (bus_wr && (bus_addr == ADR_FLAG) && bus_wdata[0]);

  always_comb begin
    if (evt)           flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = cap_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q     <= '0;
      temp_q    <= '0;
      bus_rdata <= '0;
      cap_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (cpu_lo_wr)  cap_q <= {temp_q, bus_wdata};
      else if (evt)   cap_q <= count_val;
      cap_flag <= flag_nxt;
      irq      <= flag_nxt & irq_en;
      if (bus_rd) begin
        case (bus_addr)
          ADR_CAP_LO: begin
            bus_rdata <= cap_q[BW-1:0];
            temp_q    <= cap_q[CNT_W-1:BW];
          end
          ADR_CAP_HI: bus_rdata <= temp_q;
          ADR_FLAG:   bus_rdata <= {{(BW-1){1'b0}}, cap_flag};
          default:    bus_rdata <= '0;
        endcase
      end
      if (bus_wr && (bus_addr == ADR_CAP_HI)) temp_q <= bus_wdata;
    end
  end

  AST_FLAG_WITH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    evt |=> cap_flag); // R5
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    (evt && !(bus_wr && bus_addr == ADR_CAP_LO && top_mode)) |=> cap_q == $past(count_val)); // R3
  AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_CAP_LO && !top_mode && !evt) |=> $stable(cap_q)); // R9
  AST_CPU_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt && bus_wr && bus_addr == ADR_CAP_LO && top_mode)
      |=> (cap_q == {$past(temp_q), $past(bus_wdata)}) && cap_flag); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !evt) |=> !cap_flag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> cap_flag); // R6
endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int BW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             cmp_in,
  input  logic             src_cmp_sel,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             irq_en,
  input  logic             top_mode,
  input  logic [CNT_W-1:0] count_val,
  input  logic             irq_ack,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BW-1:0]    bus_wdata,
  output logic [BW-1:0]    bus_rdata,
  output logic             cap_flag,
  output logic             irq
);
  logic src_raw;
  logic lvl;
  logic evt;

  assign src_raw = src_cmp_sel ? cmp_in : pin_in; // R1

  cap_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .raw(src_raw), .filt_en(filt_en), .lvl(lvl)
  );

  cap_edge_det u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .edge_rise(edge_rise), .evt(evt)
  );

  cap_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .evt(evt), .count_val(count_val),
    .top_mode(top_mode), .irq_en(irq_en), .irq_ack(irq_ack),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_flag(cap_flag), .irq(irq)
  );
endmodule

// File: tb/tb_capture_unit.sv
module tb_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 0, cmp_in = 0, src_cmp_sel = 0, filt_en = 0, edge_rise = 1;
  logic        irq_en = 0, top_mode = 0, irq_ack = 0;
  logic [15:0] count_val = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        cap_flag, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] last_cap = 0;

  always #2 clk = ~clk;

  capture_unit dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_cmp_sel(src_cmp_sel), .filt_en(filt_en), .edge_rise(edge_rise),
    .irq_en(irq_en), .top_mode(top_mode), .count_val(count_val),
    .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag), .irq(irq)
  );

  // {sel, rise, filt, drive_cmp, width[3:0], cnt[15:0], expect_capture}
  localparam logic [24:0] VEC [0:8] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 16'h1234, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd6, 16'h2345, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd6, 16'h3456, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 16'h4567, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd6, 16'h5678, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 16'h6789, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 16'h789A, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 16'h89AB, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 16'h9ABC, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(2'd0, lo);
    bus_read(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pin_pulse(input int w);
    @(negedge clk); pin_in = 1;
    repeat (w) @(negedge clk);
    pin_in = 0;
    idle(14);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    idle(4);
    rst = 0;
    idle(2);
    chk("R11 flag after reset", cap_flag, 0);
    chk("R11 irq after reset", irq, 0);
    chk("R11 rdata after reset", bus_rdata, 0);
    read16(v);
    chk("R11 capture register after reset", v, 16'h0000);

    // Vector table: R1 R2 R4
    for (int i = 0; i < 9; i++) begin
      logic [24:0] e;
      e = VEC[i];
      @(negedge clk);
      src_cmp_sel = e[24]; edge_rise = e[23]; filt_en = e[22];
      pin_in = 0; cmp_in = 0; count_val = e[16:1];
      idle(12);
      bus_write(2'd2, 8'h01);
      @(negedge clk);
      if (e[21]) cmp_in = 1; else pin_in = 1;
      repeat (int'(e[20:17])) @(negedge clk);
      pin_in = 0; cmp_in = 0;
      idle(14);
      chk($sformatf("R1 R2 R4 vector %0d flag", i), cap_flag, e[0]);
      read16(v);
      if (e[0]) last_cap = e[16:1];
      chk($sformatf("R1 R2 R4 vector %0d capture value", i), v, last_cap);
    end

    // R3 latency unfiltered, with R7 capture-beats-ack
    @(negedge clk); src_cmp_sel = 0; edge_rise = 1; filt_en = 0;
    bus_write(2'd2, 8'h01);
    @(negedge clk); pin_in = 1; count_val = 16'd100;
    @(negedge clk); count_val = 16'd101;
    @(negedge clk); count_val = 16'd102;
    @(negedge clk);
    chk("R3 flag not yet set at k+2", cap_flag, 0);
    count_val = 16'd103; irq_ack = 1;
    @(negedge clk);
    chk("R5 R7 flag set despite ack in capture cycle", cap_flag, 1);
    irq_ack = 0; count_val = 16'd200;
    read16(v);
    chk("R3 captured count at edge k+3", v, 16'd103);
    pin_in = 0; idle(12);

    // R4 latency filtered
    filt_en = 1;
    bus_write(2'd2, 8'h01);
    @(negedge clk); pin_in = 1; count_val = 16'd100;
    for (int j = 1; j <= 7; j++) begin
      @(negedge clk);
      if (j == 7) chk("R4 flag not yet set at k+6", cap_flag, 0);
      count_val = 16'(100 + j);
    end
    @(negedge clk);
    chk("R4 flag set at k+7", cap_flag, 1);
    read16(v);
    chk("R4 filtered captured count", v, 16'd107);
    pin_in = 0; idle(12); filt_en = 0;

    // R6 irq gating, R7 clears
    idle(2);
    chk("R6 irq low while disabled", irq, 0);
    @(negedge clk); irq_en = 1;
    @(negedge clk);
    chk("R6 irq follows flag when enabled", irq, 1);
    bus_write(2'd2, 8'h00);
    chk("R7 writing zero keeps flag", cap_flag, 1);
    bus_write(2'd2, 8'h01);
    chk("R7 write one clears flag", cap_flag, 0);
    chk("R6 irq drops with flag", irq, 0);
    pin_pulse(3);
    chk("R6 irq on new capture", irq, 1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R7 ack clears flag", cap_flag, 0);
    irq_en = 0;

    // R9 write gating, R5 flag readback
    read16(last_cap);
    top_mode = 0;
    bus_write(2'd1, 8'hAB);
    bus_write(2'd0, 8'hCD);
    read16(v);
    chk("R9 write ignored without top mode", v, last_cap);
    top_mode = 1;
    bus_write(2'd1, 8'hAB);
    bus_write(2'd0, 8'hCD);
    read16(v);
    chk("R9 write committed in top mode", v, 16'hABCD);
    bus_read(2'd2, b);
    chk("R5 flag reads zero at address 2", b, 8'h00);

    // R8 temporary byte snapshot across a capture
    bus_read(2'd0, b);
    chk("R8 low byte read", b, 8'hCD);
    count_val = 16'h1234;
    pin_pulse(3);
    bus_read(2'd2, b);
    chk("R5 flag reads one at address 2", b, 8'h01);
    bus_read(2'd1, b);
    chk("R8 high read returns snapshot", b, 8'hAB);
    read16(v);
    chk("R8 fresh 16-bit read", v, 16'h1234);

    // R10 CPU write wins over simultaneous capture
    bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'h55);
    count_val = 16'h7777;
    @(negedge clk); pin_in = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h66; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R10 flag still set", cap_flag, 1);
    read16(v);
    chk("R10 CPU value kept", v, 16'h5566);
    pin_in = 0; idle(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule